// File: doc/BRIEF.md
# Daisy-Chainable Serial Result Shifter with External Data Clock

This block is the serial result port of a 16-bit converter whose data clock is supplied from outside. When the converter's busy flag goes high, the block takes the finished conversion word. A receiver can then read that word while chip select is low and the read/convert line is high. The receiver clocks the word out with a discontinuous data clock, which may rest either low or high between bursts. No framing pulse is produced.

The external data clock is synchronised into the system clock domain, and its edges are detected there. A falling edge presents the next result bit, most significant bit first. After the sixteen data bits, the output passes on the tag input. Each tag bit appears on the output sixteen rising edges after the edge that sampled it. Several converters can therefore be chained: the output of one feeds the tag input of the next, and one long burst reads them all. A new conversion finishing reloads the register, whatever is left of the old read.

Top module: `chain_result_shifter`

## Requirements
- R1: While reset is asserted and right after it, the serial output `sdo` is 0.
- R2: A rising edge on `busy` loads `result`, and `sdo` shows `result[15]` (the MSB) at once, before any data clock edge.
- R3: The k-th accepted falling edge of the data clock, for k from 1 to 16, puts `result[16-k]` on `sdo`. The value is held across the rising edge that follows it.
- R4: Once 16 bits have been presented, further falling edges leave `sdo` unchanged. The LSB stays on `sdo` until the 17th accepted rising edge.
- R5: At the k-th accepted rising edge, for k of 17 or more, `sdo` takes the value of `tag_in` that was sampled at rising edge k-16. `tag_in` is sampled at every accepted rising edge.
- R6: A data clock edge is accepted only while `busy` is 1, `cs_n` is 0 and `rd_cnv` is 1. Any other edge moves neither the output nor the bit position.
- R7: A new rising edge on `busy` in the middle of a read drops the remaining bits. The next falling edge presents the MSB of the new word.
- R8: A data clock that rests high gives the same bit order. Its first falling edge presents the MSB, its 17th falling edge is ignored, and its 17th rising edge presents the first tag sample.
- R9: `sdo` changes only because of a load or an accepted data clock edge. With no such event it stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| busy | input | 1 | High when no conversion is in progress; its rising edge marks a finished result |
| result | input | 16 | Conversion word to send |
| cs_n | input | 1 | Active-low chip select |
| rd_cnv | input | 1 | High selects reading, low selects converting |
| dclk_ext | input | 1 | External data clock, asynchronous to `clk` |
| tag_in | input | 1 | Serial input shifted in behind the result (the previous device's output in a chain) |
| sdo | output | 1 | Registered serial data output |

## Verification
Several result words run against different tag words with a data clock that rests low. The 24-pulse bursts are long enough to cover the end of the data bits and the hand-over to the tag stream. Asymmetric bit patterns show whether bits come out in reversed order or one position off. The distinct tag words show whether a tag sample is delayed by the wrong number of rising edges. A clock that rests high separates the falling-edge-first order from the rising-edge-first order, and it exercises the ignored 17th falling edge. Directed runs with chip select high and with the read line low show that ignored edges leave the bit position where it was. A reload in the middle of a read shows that the old word is gone.

// File: rtl/xsr_pkg.sv
`timescale 1ns/1ps
package xsr_pkg;
  // Edge events of the synchronised external data clock.
  typedef struct packed {
    logic rise;
    logic fall;
  } clk_edge_t;
endpackage

// File: rtl/xsr_edge_detect.sv
`timescale 1ns/1ps
// Brings an asynchronous clock into the system domain and reports its edges.
module xsr_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                async_in,
  output xsr_pkg::clk_edge_t  edge_o
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= async_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[TOP];
  end

  assign edge_o.rise = sync_q[TOP] & ~prev_q;
  assign edge_o.fall = ~sync_q[TOP] & prev_q;
endmodule

// File: rtl/xsr_phase_ctl.sv
`timescale 1ns/1ps
// Counts accepted edges and decides whether a data bit or a tag bit goes out.
module xsr_phase_ctl #(
  parameter int DW = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               rd_en,
  input  xsr_pkg::clk_edge_t edge_i,
  output logic               rise_act,
  output logic               fall_data,
  output logic               tag_sel
);
  localparam int CW = $clog2(DW + 2);
  localparam logic [CW-1:0] DATA_N = CW'(DW);
  localparam logic [CW-1:0] RISE_N = CW'(DW + 1);

  logic [CW-1:0] rise_cnt;
  logic [CW-1:0] fall_cnt;
  logic          fall_act;

  assign rise_act  = edge_i.rise & rd_en & ~load;
  assign fall_act  = edge_i.fall & rd_en & ~load;
  assign fall_data = fall_act & (fall_cnt < DATA_N);
  assign tag_sel   = rise_act & (rise_cnt >= DATA_N);

  always_ff @(posedge clk) begin
    if (rst || load) begin
      rise_cnt <= '0;
      fall_cnt <= '0;
    end else begin
      if (rise_act && rise_cnt < RISE_N) rise_cnt <= rise_cnt + 1'b1;
      if (fall_data)                     fall_cnt <= fall_cnt + 1'b1;
    end
  end

  // R4: the data bit position never runs past the word length
  p_fall_bound_r4: assert property (@(posedge clk) disable iff (rst)
    fall_cnt <= DATA_N);
  // R5: the rising edge count saturates once the tag stream has begun
  p_rise_bound_r5: assert property (@(posedge clk) disable iff (rst)
    rise_cnt <= RISE_N);
  // R6: no bit position moves while reading is not allowed
  p_hold_pos_r6: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !load) |=> ($stable(rise_cnt) && $stable(fall_cnt)));
endmodule

// File: rtl/xsr_data_shift.sv
`timescale 1ns/1ps
// Holds the result word and moves it one place per data-phase falling edge.
module xsr_data_shift #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] word,
  input  logic          shift,
  output logic          head
);
  logic [DW-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst)        sh_q <= '0;
    else if (load)  sh_q <= word;
    else if (shift) sh_q <= {sh_q[DW-2:0], 1'b0};
  end

  assign head = sh_q[DW-1];

  // R7: a load replaces the whole word
  p_reload_r7: assert property (@(posedge clk) disable iff (rst)
    load |=> (head == $past(word[DW-1])));
endmodule

// File: rtl/xsr_tag_line.sv
`timescale 1ns/1ps
// Delay line that samples the chain input on every accepted rising edge.
module xsr_tag_line #(
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic shift,
  input  logic din,
  output logic head
);
  logic [DEPTH-1:0] tq;

  always_ff @(posedge clk) begin
    if (rst || clear) tq <= '0;
    else if (shift)   tq <= {tq[DEPTH-2:0], din};
  end

  assign head = tq[DEPTH-1];
endmodule

// File: rtl/chain_result_shifter.sv
`timescale 1ns/1ps
// Serial result output with external data clock and tag pass-through.
module chain_result_shifter #(
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy,
  input  logic [DW-1:0] result,
  input  logic          cs_n,
  input  logic          rd_cnv,
  input  logic          dclk_ext,
  input  logic          tag_in,
  output logic          sdo
);
  xsr_pkg::clk_edge_t dclk_edge;
  logic busy_q, load, rd_en;
  logic rise_act, fall_data, tag_sel;
  logic data_head, tag_head;

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= busy;
  end

  assign load  = busy & ~busy_q;
  assign rd_en = busy & ~cs_n & rd_cnv;

  xsr_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .async_in(dclk_ext), .edge_o(dclk_edge)
  );

  xsr_phase_ctl #(.DW(DW)) u_phase (
    .clk(clk), .rst(rst), .load(load), .rd_en(rd_en), .edge_i(dclk_edge),
    .rise_act(rise_act), .fall_data(fall_data), .tag_sel(tag_sel)
  );

  xsr_data_shift #(.DW(DW)) u_data (
    .clk(clk), .rst(rst), .load(load), .word(result), .shift(fall_data),
    .head(data_head)
  );

  xsr_tag_line #(.DEPTH(DW)) u_tag (
    .clk(clk), .rst(rst), .clear(load), .shift(rise_act), .din(tag_in),
    .head(tag_head)
  );

  always_ff @(posedge clk) begin
    if (rst)            sdo <= 1'b0;
    else if (load)      sdo <= result[DW-1];
    else if (fall_data) sdo <= data_head;
    else if (tag_sel)   sdo <= tag_head;
  end

  // R2: a finished conversion shows its MSB on the next cycle
  p_load_msb_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> (sdo == $past(result[DW-1])));
  // R3: a data-phase falling edge presents the shifter head
  p_data_out_r3: assert property (@(posedge clk) disable iff (rst)
    fall_data |=> (sdo == $past(data_head)));
  // R5: a tag-phase rising edge presents the oldest tag sample
  p_tag_out_r5: assert property (@(posedge clk) disable iff (rst)
    tag_sel |=> (sdo == $past(tag_head)));
  // R6: output frozen while reading is not allowed
  p_ignore_r6: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !load) |=> $stable(sdo));
  // R9: no event, no output change
  p_sdo_cause_r9: assert property (@(posedge clk) disable iff (rst)
    !(load || fall_data || tag_sel) |=> $stable(sdo));
endmodule

// File: tb/chain_result_shifter_test.sv
`timescale 1ns/1ps
module chain_result_shifter_test;
  localparam int DW = 16;
  localparam int NV = 4;
  // {result word, tag word}
  localparam logic [31:0] VEC [NV] = '{
    {16'hA5C3, 16'h1234}, {16'h8001, 16'hFFFE},
    {16'h7FF0, 16'h0F0F}, {16'h3C96, 16'hB00D}
  };

  logic clk = 0, rst = 1, busy = 0, cs_n = 1, rd_cnv = 0, dclk = 0, tag_in = 0;
  logic [DW-1:0] result = '0;
  logic sdo;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  chain_result_shifter #(.DW(DW)) uut (
    .clk(clk), .rst(rst), .busy(busy), .result(result), .cs_n(cs_n),
    .rd_cnv(rd_cnv), .dclk_ext(dclk), .tag_in(tag_in), .sdo(sdo)
  );

  task automatic check(input string req, input logic exp);
    n_run++;
    if (sdo !== exp) begin
      n_fail++;
      $display("FAIL %s: sdo=%0b expected %0b at %0t", req, sdo, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic set_dclk(input logic v);
    dclk = v;
    settle();
  endtask

  task automatic load_word(input logic [DW-1:0] w);
    busy = 0;
    settle();
    result = w;
    busy = 1;
    settle();
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] a, b, c, tw;
    repeat (4) @(negedge clk);
    check("R1 in reset", 1'b0);
    rst = 0;
    settle();
    check("R1 after reset", 1'b0);

    // Table walk: clock rests low, 24 pulses per read
    for (int v = 0; v < NV; v++) begin
      logic [DW-1:0] w, t;
      w = VEC[v][31:16];
      t = VEC[v][15:0];
      cs_n = 0; rd_cnv = 1; dclk = 0;
      load_word(w);
      check("R2 load MSB", w[DW-1]);
      for (int k = 1; k <= 24; k++) begin
        tag_in = t[(k-1)%16];
        set_dclk(1);
        if (k == 1)       check("R3 rise 1", w[15]);
        else if (k <= 16) check("R3 rise hold", w[17-k]);
        else              check("R5 tag out", t[(k-17)%16]);
        set_dclk(0);
        if (k <= 16) check("R3 fall bit", w[16-k]);
        else         check("R4 fall ignored", t[(k-17)%16]);
      end
    end

    // R6: edges ignored with chip select high, then with rd_cnv low
    a = 16'hC5A1;
    cs_n = 1; rd_cnv = 1; dclk = 0;
    load_word(a);
    for (int k = 0; k < 3; k++) begin
      set_dclk(1); set_dclk(0);
      check("R6 cs_n high", a[15]);
    end
    cs_n = 0;
    set_dclk(1); set_dclk(0);
    check("R6 first fall after enable", a[15]);
    set_dclk(1); set_dclk(0);
    check("R6 second fall", a[14]);
    rd_cnv = 0;
    for (int k = 0; k < 3; k++) begin
      set_dclk(1); set_dclk(0);
      check("R6 rd_cnv low", a[14]);
    end
    rd_cnv = 1;
    set_dclk(1); set_dclk(0);
    check("R6 resumes", a[13]);
    repeat (20) @(negedge clk);
    check("R9 stable without edges", a[13]);

    // R7: reload mid-read
    b = 16'h4E27;
    load_word(b);
    check("R7 new MSB", b[15]);
    set_dclk(1); set_dclk(0);
    check("R7 first fall", b[15]);
    set_dclk(1); set_dclk(0);
    check("R7 second fall", b[14]);

    // R8: clock resting high, falling edge first
    c = 16'h9D3B;
    tw = 16'h6A5C;
    set_dclk(1);
    load_word(c);
    check("R8 load MSB", c[15]);
    for (int k = 1; k <= 17; k++) begin
      set_dclk(0);
      if (k <= 16) check("R8 fall bit", c[16-k]);
      else         check("R8 17th fall ignored (R4)", c[0]);
      tag_in = tw[k-1];
      set_dclk(1);
      if (k <= 16) check("R8 rise hold", c[16-k]);
      else         check("R8 first tag (R5)", tw[0]);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule